// File: doc/BRIEF.md
# Shared Power-Down / Interrupt Pin Controller

This block owns one bidirectional pad that does two jobs. After reset the pad is an active-low power-down request input. Software can switch it to an active-low, open-drain interrupt output. The block holds three small registers behind a management bus, which has a 5-bit address, 16-bit data, and separate read and write strobes:

- a basic control register that holds a software power-down bit;
- an interrupt control register that holds the pin-mode bit and the interrupt-enable bit;
- a combined mask/status register.

Eight interrupt sources send single-cycle event pulses. A masked-in pulse latches a status bit. The pad is pulled low while the pin is in output mode, interrupts are enabled and any status bit is latched. Reading the status register clears the latched bits.

In input mode the pad level passes through a two-flop synchronizer. It is then ORed with the software power-down bit to form the device's power-down request. Switching the pin to output mode cuts the pad's input path. A pin held low from outside then no longer keeps the device powered down. The management bus keeps working while power-down is requested.

Top module: `pdint_pin_ctrl`

## Requirements
- R1: After reset `pad_oe` is 0 and `pd_req` is 0. Reads of addresses 0x00, 0x11 and 0x12 return 0x0000. `mg_rdata` is 0 whenever `mg_rd` is low.
- R2: With 0x11 bit 0 clear and 0x00 bit 11 clear, a low level on `pad_in` raises `pd_req` after the second rising clock edge that samples it. A return to high lowers `pd_req` after the second rising clock edge that samples it.
- R3: While 0x00 bit 11 is set, `pd_req` is 1 whatever the pad level and pin mode. It takes effect from the clock edge of the write. Bit 11 reads back at bit 11 and the other bits of 0x00 read as 0.
- R4: While 0x11 bit 0 (pin output mode) is set, `pad_in` has no effect on `pd_req`. `pd_req` then equals 0x00 bit 11, from the edge that writes the mode bit.
- R5: Status bit 8+i of 0x12 is set by a pulse on `evt_pulse[i]` only if mask bit i of 0x12 is 1. Once set, it stays set until 0x12 is read.
- R6: A read of 0x12 returns the status in bits 15:8 and the mask in bits 7:0. It then clears all status bits at that clock edge. An unmasked event pulse in the same cycle as the read is still latched.
- R7: `pad_oe` is 1 and `pad_out` is 0 exactly when 0x11 bit 0, 0x11 bit 1 and at least one status bit are all 1. Otherwise `pad_oe` is 0. The drive begins right after the edge that latches the event, with no further register stage.
- R8: A write to 0x12 changes only the mask in bits 7:0. The status byte cannot be written. Only bits 1:0 of 0x11 are stored and read back.
- R9: Writes and reads of all registers work normally while `pd_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mg_addr | input | 5 | Management register address |
| mg_wdata | input | 16 | Management write data |
| mg_wr | input | 1 | Write strobe, one cycle per write |
| mg_rd | input | 1 | Read strobe, one cycle per read |
| mg_rdata | output | 16 | Read data, valid in the cycle of `mg_rd` |
| evt_pulse | input | 8 | Interrupt source event pulses |
| pad_in | input | 1 | Pad input level (low requests power-down) |
| pad_oe | output | 1 | Pad driver enable |
| pad_out | output | 1 | Pad driven value (low while driven) |
| pd_req | output | 1 | Combined power-down request |

## Verification
The checker checks several rules on every cycle:

- the pad is never driven high;
- the software power-down bit always forces `pd_req`;
- output mode with software power-down clear always keeps `pd_req` low;
- a pad level that has been low for two sampled edges in input mode raises `pd_req`;
- a masked-in event with both control bits set drives the pad on the next cycle;
- a status read with no event releases the pad.

Only the bench scenarios can show the following:

- register read-back and the read-only status byte;
- the exact synchronizer latency in both directions;
- an event that coincides with a clearing read;
- that masked-out events leave no trace.

// File: rtl/pdint_pkg.sv
package pdint_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_BASIC = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_ICTL  = 5'h11;
    localparam logic [ADDR_W-1:0] ADR_ISTS  = 5'h12;

    localparam int SWPD_BIT = 11;

    typedef struct packed {
        logic irq_en;   // bit 1
        logic pin_oe;   // bit 0
    } ictl_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_BASIC,
        SEL_ICTL,
        SEL_ISTS
    } regsel_e;

    function automatic regsel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            ADR_BASIC: return SEL_BASIC;
            ADR_ICTL:  return SEL_ICTL;
            ADR_ISTS:  return SEL_ISTS;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pdint_sync.sv
module pdint_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pdint_regs.sv
module pdint_regs
    import pdint_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    input  logic [N_SRC-1:0]  evt,
    output logic [DATA_W-1:0] rdata,
    output logic              sw_pd,
    output ictl_t             ictl,
    output logic [N_SRC-1:0]  mask,
    output logic [N_SRC-1:0]  status
);
    regsel_e    sel;
    logic       sts_clr;
    logic       unused_wbits;

    assign sel          = decode(addr);
    assign sts_clr      = rd && (sel == SEL_ISTS);
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_pd  <= 1'b0;
            ictl   <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (wr) begin
                case (sel)
                    SEL_BASIC: sw_pd <= wdata[SWPD_BIT];
                    SEL_ICTL:  ictl  <= ictl_t'(wdata[1:0]);
                    SEL_ISTS:  mask  <= wdata[N_SRC-1:0];
                    default:   ;
                endcase
            end
            status <= (sts_clr ? '0 : status) | (evt & mask);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_BASIC: rdata[SWPD_BIT] = sw_pd;
                SEL_ICTL:  rdata[1:0] = ictl;
                SEL_ISTS: begin
                    rdata[N_SRC-1:0]        = mask;
                    rdata[BYTE_W +: N_SRC]  = status;
                end
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pdint_pin_logic.sv
module pdint_pin_logic
    import pdint_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  ictl_t            ictl,
    input  logic [N_SRC-1:0] status,
    input  logic             sw_pd,
    input  logic             pad_low_sync,
    output logic             pad_oe,
    output logic             pad_out,
    output logic             pd_req
);
    logic irq_pending;

    assign irq_pending = |status;
    assign pad_oe      = ictl.pin_oe && ictl.irq_en && irq_pending;
    assign pad_out     = !pad_oe;
    assign pd_req      = sw_pd || (!ictl.pin_oe && pad_low_sync);
endmodule

// File: rtl/pdint_pin_ctrl.sv
module pdint_pin_ctrl
    import pdint_pkg::*;
#(
    parameter int N_SRC       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mg_addr,
    input  logic [DATA_W-1:0] mg_wdata,
    input  logic              mg_wr,
    input  logic              mg_rd,
    output logic [DATA_W-1:0] mg_rdata,
    input  logic [N_SRC-1:0]  evt_pulse,
    input  logic              pad_in,
    output logic              pad_oe,
    output logic              pad_out,
    output logic              pd_req
);
    ictl_t            ictl;
    logic             cfg_oe;
    logic             cfg_en;
    logic             cfg_swpd;
    logic [N_SRC-1:0] cfg_mask;
    logic [N_SRC-1:0] sts;
    logic             pad_level_sync;

    pdint_regs #(.N_SRC(N_SRC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (mg_addr),
        .wdata  (mg_wdata),
        .wr     (mg_wr),
        .rd     (mg_rd),
        .evt    (evt_pulse),
        .rdata  (mg_rdata),
        .sw_pd  (cfg_swpd),
        .ictl   (ictl),
        .mask   (cfg_mask),
        .status (sts)
    );

    pdint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_level_sync)
    );

    assign cfg_oe = ictl.pin_oe;
    assign cfg_en = ictl.irq_en;

    pdint_pin_logic #(.N_SRC(N_SRC)) u_pin (
        .ictl         (ictl),
        .status       (sts),
        .sw_pd        (cfg_swpd),
        .pad_low_sync (!pad_level_sync),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pd_req       (pd_req)
    );
endmodule

// File: rtl/pdint_chk.sv
module pdint_chk
    import pdint_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mg_addr,
    input logic              mg_rd,
    input logic              mg_wr,
    input logic [N_SRC-1:0]  evt_pulse,
    input logic              pad_in,
    input logic              pad_oe,
    input logic              pad_out,
    input logic              pd_req,
    input logic              cfg_oe,
    input logic              cfg_en,
    input logic              cfg_swpd,
    input logic [N_SRC-1:0]  cfg_mask
);
    p_drive_low_r7: assert property (@(posedge clk) disable iff (rst)
        pad_oe |-> !pad_out);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pad_oe && !pd_req));

    p_swpd_forces_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_swpd |-> pd_req);

    p_mode_blocks_pad_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe && !cfg_swpd) |-> !pd_req);

    p_sync_low_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_oe && !$past(pad_in) && !$past(pad_in, 2)
         && !$past(rst) && !$past(rst, 2)) |-> pd_req);

    p_event_drives_r5: assert property (@(posedge clk) disable iff (rst)
        (((evt_pulse & cfg_mask) != '0) && cfg_oe && cfg_en && !mg_wr)
        |=> pad_oe);

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (mg_rd && mg_addr == ADR_ISTS && evt_pulse == '0) |=> !pad_oe);
endmodule

bind pdint_pin_ctrl pdint_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mg_addr   (mg_addr),
    .mg_rd     (mg_rd),
    .mg_wr     (mg_wr),
    .evt_pulse (evt_pulse),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pd_req    (pd_req),
    .cfg_oe    (cfg_oe),
    .cfg_en    (cfg_en),
    .cfg_swpd  (cfg_swpd),
    .cfg_mask  (cfg_mask)
);

// File: tb/sim_pdint_pin_ctrl.sv
`timescale 1ns/1ps
module sim_pdint_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mg_addr = '0;
    logic [15:0] mg_wdata = '0;
    logic        mg_wr = 1'b0;
    logic        mg_rd = 1'b0;
    logic [15:0] mg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        pad_in = 1'b1;
    logic        pad_oe, pad_out, pd_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model of architectural state
    logic       m_swpd = 0, m_oe = 0, m_en = 0;
    logic [7:0] m_mask = 0, m_sts = 0;

    always #4 clk = ~clk;

    pdint_pin_ctrl u0 (
        .clk(clk), .rst(rst), .mg_addr(mg_addr), .mg_wdata(mg_wdata),
        .mg_wr(mg_wr), .mg_rd(mg_rd), .mg_rdata(mg_rdata),
        .evt_pulse(evt_pulse), .pad_in(pad_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pd_req(pd_req)
    );

    function automatic logic [15:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return {4'b0, m_swpd, 11'b0};
            5'h11:   return {14'b0, m_en, m_oe};
            5'h12:   return {m_sts, m_mask};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic exp_drive();
        return m_oe && m_en && (m_sts != 8'h0);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        mg_addr = a; mg_wdata = d; mg_wr = 1'b1;
        @(posedge clk);
        case (a)
            5'h00: m_swpd = d[11];
            5'h11: begin m_oe = d[0]; m_en = d[1]; end
            5'h12: m_mask = d[7:0];
            default: ;
        endcase
        @(negedge clk);
        mg_wr = 1'b0;
    endtask

    // read with an optional concurrent event pulse
    task automatic rd_evt(input string req, input logic [4:0] a, input logic [7:0] ev);
        @(negedge clk);
        mg_addr = a; mg_rd = 1'b1; evt_pulse = ev;
        #1;
        chk(req, mg_rdata, exp_read(a));
        @(posedge clk);
        if (a == 5'h12) m_sts = 8'h0;
        m_sts = m_sts | (ev & m_mask);
        @(negedge clk);
        mg_rd = 1'b0; evt_pulse = '0;
    endtask

    task automatic pulse(input logic [7:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(posedge clk);
        m_sts = m_sts | (ev & m_mask);
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic chk_pins(input string req);
        chk({req, " pad_oe"},  {15'b0, pad_oe},  {15'b0, exp_drive()});
        if (pad_oe) chk({req, " pad_out"}, {15'b0, pad_out}, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", {15'b0, pad_oe}, 16'h0);
        chk("R1 pd_req", {15'b0, pd_req}, 16'h0);
        chk("R1 rdata idle", mg_rdata, 16'h0);
        rd_evt("R1 read 0x00", 5'h00, 8'h0);
        rd_evt("R1 read 0x11", 5'h11, 8'h0);
        rd_evt("R1 read 0x12", 5'h12, 8'h0);

        // R2 synchronizer latency
        @(negedge clk); pad_in = 1'b0;
        @(negedge clk); chk("R2 after one edge", {15'b0, pd_req}, 16'h0);
        @(negedge clk); chk("R2 after two edges", {15'b0, pd_req}, 16'h1);

        // R9 management access during power-down
        wr(5'h12, 16'h0055);
        rd_evt("R9 readback in pd", 5'h12, 8'h0);
        chk("R9 pd_req held", {15'b0, pd_req}, 16'h1);

        // R4 output mode blocks pad input
        wr(5'h11, 16'h0001);
        chk("R4 pd_req blocked", {15'b0, pd_req}, 16'h0);
        wr(5'h11, 16'h0000);
        chk("R4 pd_req restored", {15'b0, pd_req}, 16'h1);

        @(negedge clk); pad_in = 1'b1;
        @(negedge clk); chk("R2 release one edge", {15'b0, pd_req}, 16'h1);
        @(negedge clk); chk("R2 release two edges", {15'b0, pd_req}, 16'h0);

        // R3 software power-down in both modes
        wr(5'h00, 16'hFFFF);
        chk("R3 swpd input mode", {15'b0, pd_req}, 16'h1);
        rd_evt("R3 readback", 5'h00, 8'h0);
        wr(5'h11, 16'h0001);
        chk("R3 swpd output mode", {15'b0, pd_req}, 16'h1);
        wr(5'h00, 16'h0000);
        chk("R3 swpd cleared", {15'b0, pd_req}, 16'h0);

        // R8 status byte not writable, ictl bits only
        wr(5'h12, 16'hFF04);
        rd_evt("R8 status unwritable", 5'h12, 8'h0);
        wr(5'h11, 16'hFFFC);
        rd_evt("R8 ictl stored bits", 5'h11, 8'h0);

        // R5 masked-out event is ignored, masked-in latches
        wr(5'h11, 16'h0003);
        pulse(8'h08);
        chk_pins("R5 masked event no drive");
        rd_evt("R5 masked event no status", 5'h12, 8'h0);
        pulse(8'h04);
        chk_pins("R7 drive after event");
        rd_evt("R5 status latched", 5'h12, 8'h0);
        chk_pins("R6 released after read");

        // R6 event coincident with clearing read
        pulse(8'h04);
        rd_evt("R6 read with event", 5'h12, 8'h04);
        chk_pins("R6 event survives read");
        rd_evt("R6 status kept", 5'h12, 8'h0);

        // R7 gating by mode and enable
        pulse(8'h04);
        wr(5'h11, 16'h0002);
        chk_pins("R7 no drive input mode");
        wr(5'h11, 16'h0003);
        chk_pins("R7 drive restored");
        wr(5'h11, 16'h0001);
        chk_pins("R7 no drive when disabled");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: wr(5'h11, 16'($urandom));
                1: wr(5'h12, 16'($urandom));
                2: wr(5'h00, ($urandom_range(0, 3) == 0) ? 16'h0800 : 16'h0000);
                3: pulse(8'($urandom));
                4: rd_evt("R6 random read 0x12", 5'h12, 8'($urandom));
                default: rd_evt("R8 random read", ($urandom_range(0, 1) == 0) ? 5'h11 : 5'h00, 8'h0);
            endcase
            chk_pins("R7 random pins");
            chk("R3 random pd_req", {15'b0, pd_req}, {15'b0, m_swpd});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule